// File: doc/BRIEF.md
# Execute Unit with Barrel Shifter

This block is the combinational execute stage of a 32-bit load/store pipeline. It takes two register operands, an immediate field taken from the instruction and a set of decoded control pins. It produces one 32-bit result and four status flags within a single cycle. The operand registers that feed it and the register that captures its output belong to the surrounding pipeline.

The datapath has four parts. A constant extender widens the 15-bit immediate with either zero fill or sign fill. An operand-B multiplexer picks the register value or the widened constant. An arithmetic/logic unit works on A and the selected B. A barrel shifter moves the selected B by a 5-bit amount in a single pass. A four-way result multiplexer returns the ALU result, the shifted value, a signed set-on-less-than bit, or the widened constant. The set-on-less-than bit comes from a dedicated subtractor. It is the exclusive OR of the sign and overflow of A minus B, so it is correct even when that subtraction overflows.

All pins are plain control or data pins. The block has no stream interface, so no valid/ready handshake or back-pressure applies.

Top module: `exec_unit`

## Requirements
- R1: Arithmetic codes of `alu_fn`: 1 = A+1, 2 = A+B, 3 = A-B, 4 = A-1. All results wrap modulo 2^32.
- R2: Other codes of `alu_fn`: 0 = pass A, 5 = AND, 6 = OR, 7 = XOR, 8 = NOT A. Codes 9 to 15 give an ALU result of zero.
- R3: `flag_n` equals bit 31 of the ALU result. `flag_z` is 1 exactly when the ALU result is all zeros.
- R4: `flag_c` is the carry out of bit 31 of the adder. For A-B it is 1 when A >= B unsigned. For every non-arithmetic code both `flag_c` and `flag_v` are 0.
- R5: For arithmetic codes, `flag_v` is 1 exactly when the signed result overflows.
- R6: With `imm_sext` = 0, the 15-bit immediate is widened with 17 zero bits above it.
- R7: With `imm_sext` = 1, bit 14 of the immediate is copied into bits 31:15.
- R8: With `use_imm` = 1, the widened constant replaces `opnd_b` as the B input of both the ALU and the shifter.
- R9: With `shift_left` = 1, B shifts left by `shamt` (0 to 31) in one pass, and zeros enter at bit 0.
- R10: With `shift_left` = 0, B shifts right by `shamt`, and zeros enter at bit 31.
- R11: The set-on-less-than result is 1 exactly when A < B as signed numbers. It is taken as N XOR V of A-B, zero-extended to 32 bits, and is independent of `alu_fn`.
- R12: `result_sel` picks the output: 0 = ALU result, 1 = shifter, 2 = set-on-less-than, 3 = widened constant.
- R13: The four flags always describe the ALU result, whatever `result_sel` picks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B from the register file |
| alu_fn | input | 4 | ALU function code |
| shamt | input | 5 | Shift distance |
| shift_left | input | 1 | 1 = left shift, 0 = right shift |
| imm_fld | input | 15 | Immediate field from the instruction |
| imm_sext | input | 1 | 1 = sign-extend immediate, 0 = zero-fill |
| use_imm | input | 1 | 1 = widened constant used as operand B |
| result_sel | input | 2 | Result multiplexer select |
| result | output | 32 | Selected result |
| flag_n | output | 1 | Negative flag of the ALU result |
| flag_z | output | 1 | Zero flag of the ALU result |
| flag_c | output | 1 | Carry out of bit 31 |
| flag_v | output | 1 | Signed overflow |

## Verification
In every cycle the ALU and its flags compute alongside the shifter, the set-on-less-than subtractor or the constant path, whichever one the output shows. Vectors therefore pair a non-subtract ALU code, or an overflowing ADD, with `result_sel` pointing at the shifter, the comparison or the constant. Each vector is judged on the output word and on all four flags at once. This catches a flag that follows the wrong unit and a comparison that borrows the ALU's code.

// File: rtl/exec_unit_pkg.sv
package exec_unit_pkg;

  typedef enum logic [3:0] {
    FN_PASS = 4'd0,
    FN_INC  = 4'd1,
    FN_ADD  = 4'd2,
    FN_SUB  = 4'd3,
    FN_DEC  = 4'd4,
    FN_AND  = 4'd5,
    FN_OR   = 4'd6,
    FN_XOR  = 4'd7,
    FN_NOT  = 4'd8
  } alu_fn_e;

  typedef enum logic [1:0] {
    SEL_ALU   = 2'd0,
    SEL_SHIFT = 2'd1,
    SEL_SLT   = 2'd2,
    SEL_CONST = 2'd3
  } res_sel_e;

endpackage

// File: rtl/exec_const_ext.sv
module exec_const_ext #(
  parameter int W     = 32,
  parameter int IMM_W = 15
) (
  input  logic [IMM_W-1:0] imm_fld,
  input  logic             imm_sext,
  output logic [W-1:0]     konst
);
  localparam int FILL_W = W - IMM_W;

  logic fill_bit;

  always_comb begin
    fill_bit = imm_sext & imm_fld[IMM_W-1];
    konst    = {{FILL_W{fill_bit}}, imm_fld};
  end

  always_comb begin
    if (!$isunknown({imm_sext, imm_fld})) begin
      if (!imm_sext) begin
        p_zero_fill_r6: assert (konst[W-1:IMM_W] == '0)
          else $error("R6 upper bits not zero");
      end else begin
        p_sign_fill_r7: assert (konst[W-1:IMM_W] == {FILL_W{imm_fld[IMM_W-1]}})
          else $error("R7 upper bits not sign copies");
      end
    end
  end
endmodule

// File: rtl/exec_shifter.sv
module exec_shifter #(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  input  logic            left,
  output logic [W-1:0]    dout
);
  logic [W-1:0] stg [SH_W+1];

  assign stg[0] = din;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int DIST = 1 << k;
    always_comb begin
      if (!amt[k])   stg[k+1] = stg[k];
      else if (left) stg[k+1] = stg[k] << DIST;
      else           stg[k+1] = stg[k] >> DIST;
    end
  end

  assign dout = stg[SH_W];

  always_comb begin
    if (!$isunknown({din, amt, left})) begin
      if (amt == '0) begin
        p_zero_shift_r9: assert (dout == din)
          else $error("R9 zero distance changed data");
      end else if (left) begin
        p_left_lsb_r9: assert (dout[0] == 1'b0)
          else $error("R9 left shift did not fill zero");
      end else begin
        p_right_msb_r10: assert (dout[W-1] == 1'b0)
          else $error("R10 right shift did not fill zero");
      end
    end
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_unit_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   fn,
  output logic [W-1:0] res,
  output logic         n,
  output logic         z,
  output logic         c,
  output logic         v,
  output logic         slt_bit
);
  alu_fn_e      op;
  logic         arith;
  logic [W-1:0] y;
  logic         cin;
  logic [W:0]   sum;
  logic [W-1:0] diff;
  logic         d_v;

  assign op = alu_fn_e'(fn);

  always_comb begin
    arith = 1'b1;
    y     = '0;
    cin   = 1'b0;
    unique case (op)
      FN_INC:  begin y = '0;  cin = 1'b1; end
      FN_ADD:  begin y = b;   cin = 1'b0; end
      FN_SUB:  begin y = ~b;  cin = 1'b1; end
      FN_DEC:  begin y = '1;  cin = 1'b0; end
      default: arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, cin};

  always_comb begin
    case (op)
      FN_PASS: res = a;
      FN_AND:  res = a & b;
      FN_OR:   res = a | b;
      FN_XOR:  res = a ^ b;
      FN_NOT:  res = ~a;
      default: res = arith ? sum[W-1:0] : '0;
    endcase
    n = res[W-1];
    z = (res == '0);
    c = arith & sum[W];
    v = arith & (a[W-1] == y[W-1]) & (sum[W-1] != a[W-1]);
  end

  // dedicated comparator subtractor, independent of fn
  always_comb begin
    diff    = a + ~b + {{(W-1){1'b0}}, 1'b1};
    d_v     = (a[W-1] != b[W-1]) & (diff[W-1] != a[W-1]);
    slt_bit = diff[W-1] ^ d_v;
  end

  always_comb begin
    if (!$isunknown({a, b, fn})) begin
      if (op == FN_SUB && a == b) begin
        p_sub_equal_r4: assert (z && c && !v)
          else $error("R4 equal subtract flags wrong");
      end
      if (!arith) begin
        p_logic_no_cv_r4: assert (!c && !v)
          else $error("R4 logic op set C or V");
      end
    end
  end
endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_unit_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 15,
  parameter int SH_W  = $clog2(W)
) (
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic [3:0]       alu_fn,
  input  logic [SH_W-1:0]  shamt,
  input  logic             shift_left,
  input  logic [IMM_W-1:0] imm_fld,
  input  logic             imm_sext,
  input  logic             use_imm,
  input  logic [1:0]       result_sel,
  output logic [W-1:0]     result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  logic [W-1:0] konst;
  logic [W-1:0] b_sel;
  logic [W-1:0] alu_res;
  logic [W-1:0] shf_res;
  logic         slt_bit;
  res_sel_e     sel;

  exec_const_ext #(.W(W), .IMM_W(IMM_W)) u_const (
    .imm_fld (imm_fld),
    .imm_sext(imm_sext),
    .konst   (konst)
  );

  assign b_sel = use_imm ? konst : opnd_b;

  exec_alu #(.W(W)) u_alu (
    .a      (opnd_a),
    .b      (b_sel),
    .fn     (alu_fn),
    .res    (alu_res),
    .n      (flag_n),
    .z      (flag_z),
    .c      (flag_c),
    .v      (flag_v),
    .slt_bit(slt_bit)
  );

  exec_shifter #(.W(W), .SH_W(SH_W)) u_shf (
    .din (b_sel),
    .amt (shamt),
    .left(shift_left),
    .dout(shf_res)
  );

  assign sel = res_sel_e'(result_sel);

  always_comb begin
    unique case (sel)
      SEL_ALU:   result = alu_res;
      SEL_SHIFT: result = shf_res;
      SEL_SLT:   result = {{(W-1){1'b0}}, slt_bit};
      default:   result = konst;
    endcase
  end

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, imm_fld, imm_sext, use_imm, result_sel, alu_fn})) begin
      if (sel == SEL_SLT) begin
        p_slt_value_r11: assert (result == {{(W-1){1'b0}}, ($signed(opnd_a) < $signed(b_sel))})
          else $error("R11 set-less-than value wrong");
      end
      if (sel == SEL_CONST && !imm_sext) begin
        p_const_sel_r12: assert (result[IMM_W-1:0] == imm_fld)
          else $error("R12 constant path wrong");
      end
    end
  end
endmodule

// File: tb/exec_unit_tb_top.sv
module exec_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  fn;
    logic [4:0]  sh;
    logic        left;
    logic [14:0] imm;
    logic        sext;
    logic        useimm;
    logic [1:0]  sel;
    logic [31:0] er;
    logic [3:0]  ef;   // {N,Z,C,V}
  } vec_t;

  // R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 R13 all covered below
  localparam vec_t TBL [NV] = '{
    '{32'd5, 32'd7, 4'd2, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 32'd12, 4'b0000},
    '{32'h7FFFFFFF, 32'd1, 4'd2, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 32'h80000000, 4'b1001},
    '{32'hFFFFFFFF, 32'd1, 4'd2, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 32'h0, 4'b0110},
    '{32'd5, 32'd5, 4'd3, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 32'h0, 4'b0110},
    '{32'd3, 32'd5, 4'd3, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 32'hFFFFFFFE, 4'b1000},
    '{32'h80000000, 32'd1, 4'd3, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 32'h7FFFFFFF, 4'b0011},
    '{32'hFFFFFFFF, 32'd0, 4'd1, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 32'h0, 4'b0110},
    '{32'h0, 32'd0, 4'd4, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 32'hFFFFFFFF, 4'b1000},
    '{32'hF0F0FFFF, 32'h0FF000FF, 4'd5, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 32'h00F000FF, 4'b0000},
    '{32'hF0F0FFFF, 32'h0FF000FF, 4'd6, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 32'hFFF0FFFF, 4'b1000},
    '{32'hF0F0FFFF, 32'h0FF000FF, 4'd7, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 32'hFF00FF00, 4'b1000},
    '{32'hFFFFFFFF, 32'h0, 4'd8, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 32'h0, 4'b0100},
    '{32'h12345678, 32'h0, 4'd0, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 32'h12345678, 4'b0000},
    '{32'd5, 32'd9, 4'd15, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd0, 32'h0, 4'b0100},
    '{32'h0, 32'd1, 4'd0, 5'd31, 1'b1, 15'h0, 1'b0, 1'b0, 2'd1, 32'h80000000, 4'b0100},
    '{32'h0, 32'h80000000, 4'd0, 5'd31, 1'b0, 15'h0, 1'b0, 1'b0, 2'd1, 32'h1, 4'b0100},
    '{32'h0, 32'h12345678, 4'd0, 5'd4, 1'b1, 15'h0, 1'b0, 1'b0, 2'd1, 32'h23456780, 4'b0100},
    '{32'h0, 32'h12345678, 4'd0, 5'd8, 1'b0, 15'h0, 1'b0, 1'b0, 2'd1, 32'h00123456, 4'b0100},
    '{32'h0, 32'hDEADBEEF, 4'd0, 5'd0, 1'b1, 15'h0, 1'b0, 1'b0, 2'd1, 32'hDEADBEEF, 4'b0100},
    '{32'h0, 32'hFFFFFFFF, 4'd0, 5'd3, 1'b1, 15'h0001, 1'b0, 1'b1, 2'd1, 32'h8, 4'b0100},
    '{32'h0, 32'h0, 4'd0, 5'd0, 1'b0, 15'h4000, 1'b0, 1'b0, 2'd3, 32'h00004000, 4'b0100},
    '{32'h0, 32'h0, 4'd0, 5'd0, 1'b0, 15'h4000, 1'b1, 1'b0, 2'd3, 32'hFFFFC000, 4'b0100},
    '{32'h0, 32'h0, 4'd0, 5'd0, 1'b0, 15'h3FFF, 1'b1, 1'b0, 2'd3, 32'h00003FFF, 4'b0100},
    '{32'd3, 32'd5, 4'd0, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd2, 32'h1, 4'b0000},
    '{32'd5, 32'd3, 4'd0, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd2, 32'h0, 4'b0000},
    '{32'h80000000, 32'd1, 4'd0, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd2, 32'h1, 4'b1000},
    '{32'h7FFFFFFF, 32'hFFFFFFFF, 4'd0, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd2, 32'h0, 4'b0000},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 4'd0, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd2, 32'h0, 4'b1000},
    '{32'd10, 32'd0, 4'd2, 5'd0, 1'b0, 15'h7FFF, 1'b1, 1'b1, 2'd0, 32'd9, 4'b0010},
    '{32'hFFFFFFFE, 32'd0, 4'd0, 5'd0, 1'b0, 15'h7FFF, 1'b1, 1'b1, 2'd2, 32'h1, 4'b1000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;

  logic [31:0] opnd_a, opnd_b, result;
  logic [3:0]  alu_fn;
  logic [4:0]  shamt;
  logic        shift_left, imm_sext, use_imm;
  logic [14:0] imm_fld;
  logic [1:0]  result_sel;
  logic        flag_n, flag_z, flag_c, flag_v;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_unit dut_i (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .alu_fn    (alu_fn),
    .shamt     (shamt),
    .shift_left(shift_left),
    .imm_fld   (imm_fld),
    .imm_sext  (imm_sext),
    .use_imm   (use_imm),
    .result_sel(result_sel),
    .result    (result),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_v    (flag_v)
  );

  function automatic string tag_of(input vec_t t);
    if (t.useimm)       return "R8";
    if (t.sel == 2'd1)  return t.left ? "R9" : "R10";
    if (t.sel == 2'd2)  return "R11";
    if (t.sel == 2'd3)  return t.sext ? "R7" : "R6";
    if (t.ef[0])        return "R5";
    if (t.ef[1])        return "R4";
    if (t.fn >= 4'd1 && t.fn <= 4'd4) return "R1";
    return "R2";
  endfunction

  task automatic apply(input vec_t t);
    @(posedge clk);
    opnd_a = t.a; opnd_b = t.b; alu_fn = t.fn; shamt = t.sh;
    shift_left = t.left; imm_fld = t.imm; imm_sext = t.sext;
    use_imm = t.useimm; result_sel = t.sel;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] er, input logic [3:0] ef);
    n_chk++;
    if (result !== er || {flag_n, flag_z, flag_c, flag_v} !== ef) begin
      n_bad++;
      $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
               req, result, {flag_n, flag_z, flag_c, flag_v}, er, ef);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: expired, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    opnd_a = '0; opnd_b = '0; alu_fn = '0; shamt = '0; shift_left = 1'b0;
    imm_fld = '0; imm_sext = 1'b0; use_imm = 1'b0; result_sel = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // quiescent state: all-zero inputs give zero result and only Z (R3)
    check("R3", 32'h0, 4'b0100);

    // table walk; flags checked with every result (R13)
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      check(tag_of(TBL[i]), TBL[i].er, TBL[i].ef);
    end

    // R9 / R10: every shift distance, single bit marches to the far end
    for (int s = 0; s < 32; s++) begin
      apply('{32'h0, 32'h1, 4'd0, s[4:0], 1'b1, 15'h0, 1'b0, 1'b0, 2'd1, 32'h0, 4'b0});
      check("R9", 32'h1 << s, 4'b0100);
      apply('{32'h0, 32'h80000000, 4'd0, s[4:0], 1'b0, 15'h0, 1'b0, 1'b0, 2'd1, 32'h0, 4'b0});
      check("R10", 32'h80000000 >> s, 4'b0100);
    end

    // R8: use_imm=0 ignores the immediate entirely
    apply('{32'd1, 32'd2, 4'd2, 5'd0, 1'b0, 15'h7FFF, 1'b1, 1'b0, 2'd0, 32'h0, 4'b0});
    check("R8", 32'd3, 4'b0000);

    // R11 with an arithmetic ALU code selected: comparison ignores alu_fn, flags follow ADD (R13)
    apply('{32'h7FFFFFFF, 32'd1, 4'd2, 5'd0, 1'b0, 15'h0, 1'b0, 1'b0, 2'd2, 32'h0, 4'b0});
    check("R11", 32'h0, 4'b1001);

    // R12: constant select while ALU and shifter see other data
    apply('{32'hFFFFFFFF, 32'hAAAAAAAA, 4'd1, 5'd5, 1'b1, 15'h1234, 1'b0, 1'b0, 2'd3, 32'h0, 4'b0});
    check("R12", 32'h00001234, 4'b0110);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule